// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory array. A 16-bit external address is captured on a clock edge where one of two active-low address strobes is asserted: a processor strobe or a controller strobe. After the capture, the two least significant address bits step through a four-beat burst under an active-low advance input. The upper fourteen bits stay fixed for the whole burst. A static mode pin selects interleaved order (XOR of the start value with a beat count) or linear order (modulo-4 increment).

Three chip enables qualify a new burst: the first and third are active low and the second is active high. They are looked at only on strobe cycles, and the two strobes treat an inactive first enable differently. Between strobes the selection is kept. Holding the advance input inactive suspends the burst, which inserts a wait state.

The block reports four things, all registered: the current array address, a selected flag, the cycle type (read or write) and a burst-active flag. The burst-active flag drops once the burst wraps past its fourth beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `arr_addr`=0, `selected`=0, `burst_active`=0 and `is_write`=0.
- R2: A processor start is `strobe_proc_n`=0 with `ce1_n`=0, `ce2`=1 and `ce3_n`=0. On the edge after it, `arr_addr` equals the sampled `addr_in`, `selected`=1 and `burst_active`=1. `is_write`=0 even if the write controls are active.
- R3: When `strobe_proc_n`=0 and `ce1_n`=1, the processor strobe is ignored. If `strobe_ctrl_n`=1 on that edge, the cycle acts as a continue or suspend cycle and `addr_in` is not loaded.
- R4: Any of these deselects the block on the next edge (`selected`=0, `burst_active`=0): `strobe_ctrl_n`=0 with `ce1_n`=1; a controller strobe with `ce2`=0 or `ce3_n`=1; a processor strobe with `ce1_n`=0 and `ce2`=0 or `ce3_n`=1.
- R5: A controller strobe with all three enables active (and no processor start) loads `addr_in` and sets `selected`. `is_write` is then 1 when `all_wr_n`=0, or when `byte_wr_en_n`=0 and at least one bit of `byte_sel_n` is 0. Otherwise `is_write` is 0.
- R6: With `mode_interleave`=1, the low two address bits of beats 0..3 are start XOR 0, 1, 2, 3.
- R7: With `mode_interleave`=0, the low two address bits of beats 0..3 are start + 0, 1, 2, 3, modulo 4.
- R8: On cycles without a load, `arr_addr[15:2]` does not change.
- R9: On a cycle with no load and no deselect, `adv_n`=0 while selected moves to the next beat. `adv_n`=1 holds `arr_addr` unchanged.
- R10: On cycles with no strobe acting, `ce2` and `ce3_n` have no effect and `selected` keeps its value.
- R11: An advance from the fourth beat returns to the loaded start address and clears `burst_active`.
- R12: On continue and suspend cycles, `is_write` follows the write controls (same decode as R5) while selected. It is 0 while deselected, and `burst_active` is never 1 while `selected` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_in | input | 16 | External word address |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | First chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| all_wr_n | input | 1 | Write-all-bytes control, active low |
| byte_wr_en_n | input | 1 | Byte write qualifier, active low |
| byte_sel_n | input | 4 | Per-byte write selects, active low |
| arr_addr | output | 16 | Current array word address |
| selected | output | 1 | Device selected |
| is_write | output | 1 | 1 for a write cycle, 0 for a read |
| burst_active | output | 1 | Burst in progress, before its wrap |

## Verification
The bench goes after the strobe priority rules. It drives a processor strobe with the first enable off and checks that a new address is not loaded. A design that skips this check would jump to `addr_in`. It also drives the controller strobe under the same condition and expects a deselect; a design that treats the two strobes alike would keep running the old burst.

The bench walks full bursts in both orders from nonzero start values and runs them past the fourth beat. A design with the orders swapped, or with a carry into bit 2, gives wrong low bits or a changed upper field. A design that stops at the last beat stays there and keeps `burst_active` high.

Suspend cycles, enable toggling between strobes and write controls on a processor start are each checked. A design that samples enables all the time drops the selection. One that lets writes through on a processor start reports a write on the first beat.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [2:0] {
    CMD_HOLD    = 3'd0,
    CMD_STEP    = 3'd1,
    CMD_LOAD_RD = 3'd2,
    CMD_LOAD_WR = 3'd3,
    CMD_DESEL   = 3'd4
  } bas_cmd_e;
endpackage

// File: rtl/bas_decode.sv
module bas_decode
  import bas_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             strobe_proc_n,
  input  logic             strobe_ctrl_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_en_n,
  input  logic [BYTES-1:0] byte_sel_n,
  output bas_cmd_e         cmd,
  output logic             wr_now
);
  logic proc_go;
  logic ctrl_go;
  logic late_ok;

  // Second and third enables matter only once a strobe is accepted.
  assign late_ok = ce2 && !ce3_n;
  assign proc_go = !strobe_proc_n && !ce1_n;
  assign ctrl_go = !strobe_ctrl_n;
  assign wr_now  = !all_wr_n || (!byte_wr_en_n && (byte_sel_n != {BYTES{1'b1}}));

  always_comb begin
    if (proc_go) begin
      cmd = late_ok ? CMD_LOAD_RD : CMD_DESEL;
    end else if (ctrl_go) begin
      if (ce1_n || !late_ok) cmd = CMD_DESEL;
      else                   cmd = wr_now ? CMD_LOAD_WR : CMD_LOAD_RD;
    end else begin
      cmd = adv_n ? CMD_HOLD : CMD_STEP;
    end
  end
endmodule

// File: rtl/bas_counter.sv
module bas_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] offset_q,
  output logic [CNT_W-1:0] offset_d,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_comb begin
    if (load)      offset_d = '0;
    else if (step) offset_d = offset_q + 1'b1;
    else           offset_d = offset_q;
  end

  assign wrap = step && !load && (offset_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) offset_q <= '0;
    else     offset_q <= offset_d;
  end
endmodule

// File: rtl/bas_order.sv
module bas_order #(
  parameter int CNT_W = 2
) (
  input  logic             interleave,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] offset,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin;
  logic [CNT_W-1:0] ilv;

  assign lin = start + offset;

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    assign ilv[b] = start[b] ^ offset[b];
  end

  assign low = interleave ? ilv : lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_interleave,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              all_wr_n,
  input  logic              byte_wr_en_n,
  input  logic [BYTES-1:0]  byte_sel_n,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              selected,
  output logic              is_write,
  output logic              burst_active
);
  localparam int HI_W = ADDR_W - CNT_W;

  bas_cmd_e          cmd;
  logic              wr_now;
  logic              load;
  logic              step;
  logic              wrap;
  logic [CNT_W-1:0]  offset_q;
  logic [CNT_W-1:0]  offset_d;
  logic [CNT_W-1:0]  low_d;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic              sel_q;
  logic              act_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;

  bas_decode #(.BYTES(BYTES)) u_decode (
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .adv_n         (adv_n),
    .ce1_n         (ce1_n),
    .ce2           (ce2),
    .ce3_n         (ce3_n),
    .all_wr_n      (all_wr_n),
    .byte_wr_en_n  (byte_wr_en_n),
    .byte_sel_n    (byte_sel_n),
    .cmd           (cmd),
    .wr_now        (wr_now)
  );

  assign load = (cmd == CMD_LOAD_RD) || (cmd == CMD_LOAD_WR);
  assign step = (cmd == CMD_STEP) && sel_q;

  bas_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .offset_q (offset_q),
    .offset_d (offset_d),
    .wrap     (wrap)
  );

  assign base_d = load ? addr_in : base_q;

  bas_order #(.CNT_W(CNT_W)) u_order (
    .interleave (mode_interleave),
    .start      (base_d[CNT_W-1:0]),
    .offset     (offset_d),
    .low        (low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
      sel_q  <= 1'b0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      addr_q <= {base_d[ADDR_W-1 -: HI_W], low_d};
      unique case (cmd)
        CMD_LOAD_RD: begin
          sel_q <= 1'b1;
          act_q <= 1'b1;
          wr_q  <= 1'b0;
        end
        CMD_LOAD_WR: begin
          sel_q <= 1'b1;
          act_q <= 1'b1;
          wr_q  <= 1'b1;
        end
        CMD_DESEL: begin
          sel_q <= 1'b0;
          act_q <= 1'b0;
          wr_q  <= 1'b0;
        end
        CMD_STEP: begin
          wr_q <= sel_q && wr_now;
          if (wrap) act_q <= 1'b0;
        end
        default: begin
          wr_q <= sel_q && wr_now;
        end
      endcase
    end
  end

  assign arr_addr     = addr_q;
  assign selected     = sel_q;
  assign is_write     = wr_q;
  assign burst_active = act_q;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_proc_n,
  input logic              strobe_ctrl_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              selected,
  input logic              is_write,
  input logic              burst_active
);
  logic quiet;
  logic proc_start;
  assign quiet      = (strobe_proc_n || ce1_n) && strobe_ctrl_n;
  assign proc_start = !strobe_proc_n && !ce1_n && ce2 && !ce3_n;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (arr_addr == '0) && !selected && !burst_active && !is_write);

  assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
    proc_start |=> (arr_addr == $past(addr_in)) && selected && !is_write && burst_active);

  assert_ctrl_desel_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ctrl_n && ce1_n) |=> !selected && !burst_active);

  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(arr_addr[ADDR_W-1:2]));

  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (quiet && adv_n) |=> $stable(arr_addr));

  assert_sel_kept_R10: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(selected));

  assert_active_needs_sel_R12: assert property (@(posedge clk) disable iff (rst)
    !selected |-> !burst_active && !is_write);
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W)) u_bas_checker (
  .clk           (clk),
  .rst           (rst),
  .addr_in       (addr_in),
  .strobe_proc_n (strobe_proc_n),
  .strobe_ctrl_n (strobe_ctrl_n),
  .adv_n         (adv_n),
  .ce1_n         (ce1_n),
  .ce2           (ce2),
  .ce3_n         (ce3_n),
  .arr_addr      (arr_addr),
  .selected      (selected),
  .is_write      (is_write),
  .burst_active  (burst_active)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_interleave = 1'b1;
  logic [15:0] addr_in = '0;
  logic        strobe_proc_n = 1'b1;
  logic        strobe_ctrl_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        ce1_n = 1'b0;
  logic        ce2 = 1'b1;
  logic        ce3_n = 1'b0;
  logic        all_wr_n = 1'b1;
  logic        byte_wr_en_n = 1'b1;
  logic [3:0]  byte_sel_n = 4'hF;
  logic [15:0] arr_addr;
  logic        selected;
  logic        is_write;
  logic        burst_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst(rst), .mode_interleave(mode_interleave), .addr_in(addr_in),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .all_wr_n(all_wr_n),
    .byte_wr_en_n(byte_wr_en_n), .byte_sel_n(byte_sel_n),
    .arr_addr(arr_addr), .selected(selected), .is_write(is_write),
    .burst_active(burst_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    all_wr_n = 1'b1; byte_wr_en_n = 1'b1; byte_sel_n = 4'hF;
  endtask

  task automatic proc_load(input logic [15:0] a);
    idle(); addr_in = a; strobe_proc_n = 1'b0;
    cyc(); idle();
  endtask

  task automatic ctrl_load(input logic [15:0] a);
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b0; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; addr_in = a;
    cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R1 addr", arr_addr, 0);
    chk("R1 selected", selected, 0);
    chk("R1 active", burst_active, 0);
    chk("R1 write", is_write, 0);
  endtask

  task automatic t_interleave();
    logic [15:0] exp_seq [4] = '{16'hABCE, 16'hABCF, 16'hABCC, 16'hABCD};
    mode_interleave = 1'b1;
    idle(); addr_in = 16'hABCE; strobe_proc_n = 1'b0; all_wr_n = 1'b0;
    cyc(); idle();
    chk("R2 load addr", arr_addr, 16'hABCE);
    chk("R2 selected", selected, 1);
    chk("R2 read on proc start", is_write, 0);
    chk("R2 active", burst_active, 1);
    for (int k = 1; k < 4; k++) begin
      adv_n = 1'b0; cyc();
      chk("R6 R8 interleaved beat", arr_addr, exp_seq[k]);
    end
    chk("R11 active before wrap", burst_active, 1);
    adv_n = 1'b0; cyc(); idle();
    chk("R11 wrap to start", arr_addr, 16'hABCE);
    chk("R11 active cleared", burst_active, 0);
    proc_load(16'h0011);
    for (int k = 1; k < 4; k++) begin
      adv_n = 1'b0; cyc();
      chk("R6 interleaved from 01", arr_addr, 16'h0011 ^ 16'(k));
    end
    idle();
  endtask

  task automatic t_linear();
    mode_interleave = 1'b0;
    ctrl_load(16'h1235);
    chk("R5 ctrl load addr", arr_addr, 16'h1235);
    chk("R5 ctrl read", is_write, 0);
    chk("R5 selected", selected, 1);
    adv_n = 1'b0; cyc(); chk("R7 beat1", arr_addr, 16'h1236);
    cyc(); chk("R7 beat2", arr_addr, 16'h1237);
    cyc(); chk("R7 R8 beat3 wrap low bits", arr_addr, 16'h1234);
    cyc(); chk("R11 linear wrap", arr_addr, 16'h1235);
    chk("R11 linear active cleared", burst_active, 0);
    idle();
  endtask

  task automatic t_suspend();
    mode_interleave = 1'b0;
    proc_load(16'h4000);
    adv_n = 1'b1; cyc(); cyc();
    chk("R9 suspend holds", arr_addr, 16'h4000);
    adv_n = 1'b0; cyc();
    chk("R9 resume advances", arr_addr, 16'h4001);
    adv_n = 1'b1; cyc();
    chk("R9 second hold", arr_addr, 16'h4001);
    idle();
  endtask

  task automatic t_ignore();
    mode_interleave = 1'b1;
    proc_load(16'h2220);
    strobe_proc_n = 1'b0; ce1_n = 1'b1; addr_in = 16'h5555; adv_n = 1'b1;
    cyc(); idle();
    chk("R3 ignored proc keeps addr", arr_addr, 16'h2220);
    chk("R3 ignored proc keeps sel", selected, 1);
    strobe_proc_n = 1'b0; ce1_n = 1'b1; addr_in = 16'h7777; adv_n = 1'b0;
    cyc(); idle();
    chk("R3 ignored proc continues burst", arr_addr, 16'h2221);
    ce2 = 1'b0; ce3_n = 1'b1; ce1_n = 1'b1; cyc();
    chk("R10 enables ignored off strobe", selected, 1);
    chk("R10 addr kept", arr_addr, 16'h2221);
    idle();
  endtask

  task automatic t_desel();
    proc_load(16'h3000);
    strobe_ctrl_n = 1'b0; ce1_n = 1'b1; addr_in = 16'h3333;
    cyc(); idle();
    chk("R4 ctrl with ce1 off desel", selected, 0);
    chk("R4 active cleared", burst_active, 0);
    all_wr_n = 1'b0; adv_n = 1'b0; cyc();
    chk("R12 no write when deselected", is_write, 0);
    idle();
    proc_load(16'h3100);
    idle(); strobe_proc_n = 1'b0; ce2 = 1'b0; cyc(); idle();
    chk("R4 proc with ce2 off desel", selected, 0);
    ctrl_load(16'h3200);
    strobe_ctrl_n = 1'b0; ce3_n = 1'b1; cyc(); idle();
    chk("R4 ctrl with ce3 off desel", selected, 0);
  endtask

  task automatic t_write();
    mode_interleave = 1'b0;
    byte_wr_en_n = 1'b0; byte_sel_n = 4'b1101; strobe_ctrl_n = 1'b0;
    addr_in = 16'h6000; cyc(); idle();
    chk("R5 byte write load", is_write, 1);
    strobe_ctrl_n = 1'b0; all_wr_n = 1'b0; addr_in = 16'h6100; cyc(); idle();
    chk("R5 all-byte write load", is_write, 1);
    strobe_ctrl_n = 1'b0; byte_wr_en_n = 1'b0; byte_sel_n = 4'hF;
    addr_in = 16'h6200; cyc(); idle();
    chk("R5 no lane selected is read", is_write, 0);
    adv_n = 1'b0; byte_wr_en_n = 1'b0; byte_sel_n = 4'b0111; cyc();
    chk("R12 continue write", is_write, 1);
    chk("R12 continue addr", arr_addr, 16'h6201);
    idle(); cyc();
    chk("R12 hold read", is_write, 0);
  endtask

  initial begin
    idle();
    cyc(); cyc();
    rst = 1'b0;
    t_reset();
    t_interleave();
    t_linear();
    t_suspend();
    t_ignore();
    t_desel();
    t_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule